// File: doc/BRIEF.md
# Receive Bad-FCS Frame Counter

This block observes a byte-wide receive stream, one byte per clock while the frame-valid level is high, and computes a CRC-32 over each frame. The CRC covers every byte the stream carries, from the first address byte through the four trailing FCS bytes. When frame-valid falls, the block tests the running CRC against the fixed CRC-32 residue. If the frame fails and the test-traffic enable level is high in that same cycle, an 8-bit error counter goes up by one.

Software reads the count with a one-cycle read strobe. The count output carries the value at all times, and a strobe returns that value and clears the counter. The counter saturates and does not wrap, so a long unattended run cannot report a small number.

Top module: `rx_fcs_err_counter`

## Requirements
- R1: A frame whose CRC check fails, ending while `gen_en` is high, raises `err_cnt` by exactly one. The new value is visible in the cycle after the frame-end cycle.
- R2: A frame whose CRC check passes leaves `err_cnt` unchanged.
- R3: The CRC runs LSB-first over every byte presented with `rx_valid` high, using polynomial 0x04C11DB7 and a preset of all ones. A frame passes when the register, in normal bit order, equals 0xC704DD7B. Frames from 1 payload byte plus 4 FCS bytes upward are judged correctly. The FCS is the inverted CRC of the payload, sent least significant byte first.
- R4: A frame ends in the first cycle where `rx_valid` is low after having been high. `gen_en` is sampled only in that cycle. A failed frame that ends with `gen_en` low is not counted.
- R5: During a cycle with `rd_stb` high, `err_cnt` shows the accumulated count. In the following cycle the counter is zero unless R7 applies.
- R6: The counter saturates at 255. Further failed frames leave it at 255.
- R7: If a counted failed frame ends in the same cycle as `rd_stb`, the read shows the old value and the counter then holds 1.
- R8: While `rst_n` is low, `err_cnt` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 8 | Receive byte |
| rx_valid | input | 1 | High for each byte of a frame; its fall marks the frame end |
| gen_en | input | 1 | Test-traffic enable; gates counting |
| rd_stb | input | 1 | One-cycle read strobe; clears the counter |
| err_cnt | output | 8 | Current failed-frame count |

## Verification
Two events can land in one cycle: a counted failed frame finishing, and a software read clearing the counter. The bench provokes this by raising `rd_stb` in the very cycle where `rx_valid` drops after a corrupted frame. It checks that the value shown during the strobe is the pre-increment count, and that the next cycle reads 1 rather than 0. The same collision is also driven with a good frame, where the counter must clear to 0, and with `gen_en` low, where the counter must also clear to 0.

// File: rtl/rx_fcs_pkg.sv
package rx_fcs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CRC_W  = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [CRC_W-1:0] CRC_RESIDUE   = 32'hC704DD7B;

  function automatic logic [CRC_W-1:0] crc_byte_step(
    input logic [CRC_W-1:0]  crc_in,
    input logic [BYTE_W-1:0] din
  );
    logic [CRC_W-1:0] c;
    logic             fb;
    c = crc_in;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[0] ^ din[i];
      c  = {1'b0, c[CRC_W-1:1]};
      if (fb) c = c ^ CRC_POLY_REFL;
    end
    return c;
  endfunction

  function automatic logic [CRC_W-1:0] bit_reverse(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/rx_fcs_frame_track.sv
module rx_fcs_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  output logic frame_start,
  output logic frame_end
);
  logic in_frame_q;
  logic in_frame_d;

  always_comb begin
    in_frame_d  = rx_valid;
    frame_start = rx_valid & ~in_frame_q;
    frame_end   = in_frame_q & ~rx_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_frame_q <= 1'b0;
    else        in_frame_q <= in_frame_d;
  end
endmodule

// File: rtl/rx_fcs_crc_acc.sv
module rx_fcs_crc_acc
  import rx_fcs_pkg::*;
#(
  parameter logic [CRC_W-1:0] RESIDUE = CRC_RESIDUE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  input  logic              frame_start,
  output logic              crc_fail
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_d;
  logic [CRC_W-1:0] crc_seed;
  logic             crc_en;

  always_comb begin
    crc_seed = frame_start ? {CRC_W{1'b1}} : crc_q;
    crc_en   = rx_valid;
    crc_d    = crc_byte_step(crc_seed, rx_data);
    crc_fail = (bit_reverse(crc_q) != RESIDUE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= {CRC_W{1'b1}};
    else if (crc_en) crc_q <= crc_d;
  end
endmodule

// File: rtl/rx_fcs_sat_cnt.sv
module rx_fcs_sat_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | hit;
    if (clr)                        cnt_d = hit ? CNT_ONE : '0;
    else if (hit && cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
    else                            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rx_fcs_err_counter.sv
module rx_fcs_err_counter
  import rx_fcs_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_data,
  input  logic             rx_valid,
  input  logic             gen_en,
  input  logic             rd_stb,
  output logic [CNT_W-1:0] err_cnt
);
  logic frame_start;
  logic frame_end;
  logic crc_fail;
  logic err_hit;

  rx_fcs_frame_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .frame_start (frame_start),
    .frame_end   (frame_end)
  );

  rx_fcs_crc_acc #(.RESIDUE(CRC_RESIDUE)) u_crc (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .frame_start (frame_start),
    .crc_fail    (crc_fail)
  );

  assign err_hit = frame_end & crc_fail & gen_en;

  rx_fcs_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (err_hit),
    .clr   (rd_stb),
    .cnt   (err_cnt)
  );
endmodule

// File: rtl/rx_fcs_err_counter_chk.sv
module rx_fcs_err_counter_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gen_en,
  input logic             rd_stb,
  input logic             frame_end,
  input logic             crc_fail,
  input logic [CNT_W-1:0] err_cnt
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  logic counted;
  assign counted = frame_end & crc_fail & gen_en;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_zero_r8: assert (err_cnt == '0);
    end
  end

  p_bad_inc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && counted && err_cnt != MAXV) |=> err_cnt == $past(err_cnt) + 1'b1);

  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !counted) |=> $stable(err_cnt));

  p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !gen_en) |=> $stable(err_cnt));

  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !counted) |=> err_cnt == '0);

  p_saturate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && err_cnt == MAXV) |=> err_cnt == MAXV);

  p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && counted) |=> err_cnt == 1);
endmodule

bind rx_fcs_err_counter rx_fcs_err_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .gen_en    (gen_en),
  .rd_stb    (rd_stb),
  .frame_end (frame_end),
  .crc_fail  (crc_fail),
  .err_cnt   (err_cnt)
);

// File: tb/rx_fcs_err_counter_tb.sv
module rx_fcs_err_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       gen_en;
  logic       rd_stb;
  logic [7:0] err_cnt;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  int cycles = 0;
  logic [7:0] fbuf [0:19];

  rx_fcs_err_counter u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .gen_en(gen_en), .rd_stb(rd_stb), .err_cnt(err_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int k = 0; k < 8; k++) begin
      if ((r[0] ^ b[k]) == 1'b1) r = (r >> 1) ^ 32'hEDB88320;
      else                       r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind: 0 good, 1 payload bit flipped, 2 FCS bit flipped
  task automatic send_frame(input int plen, input int kind, input bit collide, input string req);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [31:0] fcs;
    int hit;
    for (int i = 0; i < plen; i++) begin
      fbuf[i] = 8'(i * 37 + plen * 11 + 5);
      c = ref_crc(c, fbuf[i]);
    end
    fcs = ~c;
    for (int i = 0; i < 4; i++) fbuf[plen+i] = fcs[8*i +: 8];
    if (kind == 1) fbuf[0] ^= 8'h01;
    if (kind == 2) fbuf[plen+3] ^= 8'h80;
    for (int i = 0; i < plen + 4; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fbuf[i];
    end
    @(negedge clk);
    rx_valid = 1'b0;
    rx_data  = 8'h00;
    hit = (kind != 0 && gen_en) ? 1 : 0;
    if (collide) begin
      rd_stb = 1'b1;
      #1 check({req, " R7 read value"}, err_cnt, exp_cnt);
      @(negedge clk);
      rd_stb  = 1'b0;
      exp_cnt = hit;
      check({req, " R7 after collide"}, err_cnt, exp_cnt);
    end else begin
      @(negedge clk);
      if (hit == 1 && exp_cnt < 255) exp_cnt++;
      check(req, err_cnt, exp_cnt);
    end
  endtask

  task automatic do_read();
    @(negedge clk);
    rd_stb = 1'b1;
    #1 check("R5 read value", err_cnt, exp_cnt);
    @(negedge clk);
    rd_stb  = 1'b0;
    exp_cnt = 0;
    check("R5 cleared", err_cnt, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; rx_data = 8'h00; rx_valid = 1'b0; gen_en = 1'b0; rd_stb = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset value", err_cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", err_cnt, 0);

    // Sweep: lengths, frame kinds, gate level (R1 R2 R3 R4)
    for (int g = 0; g < 2; g++) begin
      gen_en = g[0];
      for (int len = 1; len <= 14; len++) begin
        for (int kind = 0; kind < 3; kind++) begin
          if (kind == 0)       send_frame(len, kind, 1'b0, "R2 R3 good frame");
          else if (g == 0)     send_frame(len, kind, 1'b0, "R4 gated off");
          else                 send_frame(len, kind, 1'b0, "R1 R3 bad frame");
        end
      end
      do_read();
    end

    // Read of zero stays zero
    do_read();

    // Collision cases (R7, R5)
    gen_en = 1'b1;
    send_frame(3, 1, 1'b0, "R1 pre-collide");
    send_frame(4, 2, 1'b0, "R1 pre-collide");
    send_frame(5, 1, 1'b1, "R7 bad+read");
    send_frame(2, 0, 1'b1, "R7 good+read");
    gen_en = 1'b0;
    send_frame(2, 1, 1'b1, "R7 gated+read");
    gen_en = 1'b1;

    // Saturation (R6)
    for (int n = 0; n < 262; n++) send_frame(1, 1 + (n % 2), 1'b0, "R6 saturate");
    check("R6 held at max", err_cnt, 255);
    send_frame(6, 0, 1'b0, "R6 good at max");
    do_read();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule